// File: doc/BRIEF.md
# Ethernet Transmit Outcome Status Monitor

The block sits next to a half-duplex Ethernet transmitter. It watches the transmit handshake one bit time at a time, where one clock cycle is one bit time. From that activity it works out how each transmit attempt and each frame ended, and records the results as sticky flags in a 32-bit status word. Some flags are simple copies of event pulses: a FIFO parity error, a finished control frame, a descriptor the DMA does not own, and an empty DMA buffer. The others come from windows the block times itself: the run of consecutive colliding attempts, the number of bits sent before a collision, and how long the line stays idle while a retry is owed.

A frame is made of one or more attempts, and an attempt is one continuous high period of `tx_en`. An attempt that collides is a retry of the same frame. An attempt that ends without a collision finishes the frame. On the sixteenth consecutive colliding attempt the block abandons the frame and pulses `frame_abort`. Software reads the word on `cpu_rdata` and clears flags by writing ones. An interrupt line reports any flag whose enable bit is set.

Top module: `eth_tx_status_mon`

## Requirements
- R1: After synchronous reset, `cpu_rdata` is 0x00000000 and `irq` and `frame_abort` are 0.
- R2: A write with `cpu_wr` clears each status bit that has a 1 in `cpu_wdata`. Bits with a 0 in `cpu_wdata` are left as they were. When a bit's set event and its clear arrive in the same cycle, the bit ends up set.
- R3: Bits 15:7 and 31:19 always read as 0.
- R4: The first collision in an attempt counts that attempt as a collided attempt. When the 16th consecutive collided attempt of a frame sees its collision, bit 0 sets and `frame_abort` is 1 for exactly the next cycle. The consecutive count returns to zero when a frame completes or is aborted.
- R5: Bit 1 sets when `fifo_empty` is high in a cycle where `tx_en` is high and the frame has not been aborted. When `tx_en` is low, `fifo_empty` has no effect.
- R6: After a collided attempt ends, if `tx_en` stays low for 24,284 consecutive cycles (counting the first low cycle), bit 2 sets on the last of those cycles. If `tx_en` rises earlier, bit 2 does not set.
- R7: When an attempt ends, bit 3 sets if `crs` was low in every cycle in which `tx_en` was high.
- R8: Bit 4 sets when a collision arrives in an attempt cycle with index 512 or higher, where the first cycle of `tx_en` high has index 0. A collision at index 511 or lower does not set it.
- R9: Bit 5 sets on `fifo_par_err`, bit 16 on `ctrl_sent`, bit 17 on `dma_not_owner` and bit 18 on `dma_buf_empty`, in the cycle after the pulse.
- R10: Bit 6 sets when an attempt ends without a collision, which completes the frame. It also sets when a frame is aborted.
- R11: `irq` is the OR of the status bits ANDed with `irq_en`, and it is updated at the same clock edge as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter is driving the line (one attempt per high period) |
| col | input | 1 | Collision seen this cycle |
| crs | input | 1 | Carrier sense |
| fifo_empty | input | 1 | Transmit FIFO has no data |
| fifo_par_err | input | 1 | Parity error pulse from the transmit FIFO |
| ctrl_sent | input | 1 | Pulse: a control frame has been fully sent |
| dma_not_owner | input | 1 | Pulse: transmission stopped, the descriptor is not owned by the DMA |
| dma_buf_empty | input | 1 | Pulse: the DMA transmit buffer is empty |
| cpu_wr | input | 1 | Write strobe for clearing flags |
| cpu_wdata | input | 32 | Write-one-to-clear mask |
| irq_en | input | 32 | Per-bit interrupt enable |
| cpu_rdata | output | 32 | Status word |
| frame_abort | output | 1 | One-cycle pulse when a frame is abandoned |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things: that a set event wins over a clear, that a write of ones empties the bits it names, that the interrupt follows the enabled status, and that the abort pulse lasts one cycle and always comes with the excessive-collision and completion flags. They also check that the collision and idle counters stay inside their limits. Some behaviour only the bench scenarios can show. That covers the exact 511/512 late-collision boundary, the idle window that is one cycle short of the deferral limit against the one that reaches it, the count of fifteen against sixteen collided attempts, and the count starting again from zero after an abort. Each of these needs a built-up stimulus history before the outcome can be seen.

// File: rtl/eth_txmon_pkg.sv
package eth_txmon_pkg;
  localparam int STAT_W = 32;

  localparam int B_EXCOL = 0;
  localparam int B_UNDR  = 1;
  localparam int B_DEFER = 2;
  localparam int B_NOCRS = 3;
  localparam int B_LATE  = 4;
  localparam int B_PAR   = 5;
  localparam int B_DONE  = 6;
  localparam int B_CTRL  = 16;
  localparam int B_NOOWN = 17;
  localparam int B_BUFE  = 18;

  localparam logic [STAT_W-1:0] VALID_MASK = 32'h0007_007F;

  // per-cycle outcome of the attempt tracker
  typedef struct packed {
    logic excol;
    logic undr;
    logic nocrs;
    logic late;
    logic done;
    logic retry;
  } frame_ev_t;
endpackage

// File: rtl/eth_txmon_frame.sv
module eth_txmon_frame
  import eth_txmon_pkg::*;
#(
  parameter int LATE_BITS = 512,
  parameter int MAX_COLL  = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic      col,
  input  logic      crs,
  input  logic      fifo_empty,
  output frame_ev_t ev,
  output logic      frame_abort
);
  localparam int BCW = $clog2(LATE_BITS) + 1;
  localparam int CCW = $clog2(MAX_COLL + 1);
  localparam logic [BCW-1:0] LATE_V = BCW'(LATE_BITS);
  localparam logic [CCW-1:0] LAST_C = CCW'(MAX_COLL - 1);

  logic           tx_d;
  logic [BCW-1:0] bit_cnt;
  logic [CCW-1:0] coll_cnt;
  logic           att_col;
  logic           aborted;
  logic           crs_seen;

  logic active, col_hit, first_col, hit_max, fall;

  always_comb begin
    active    = tx_en && !aborted;
    col_hit   = active && col;
    first_col = col_hit && !att_col;
    hit_max   = first_col && (coll_cnt == LAST_C);
    fall      = tx_d && !tx_en;

    ev.excol = hit_max;
    ev.undr  = active && fifo_empty;
    ev.late  = col_hit && (bit_cnt >= LATE_V);
    ev.nocrs = fall && !crs_seen;
    ev.done  = hit_max || (fall && !aborted && !att_col);
    ev.retry = fall && !aborted && att_col;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d        <= 1'b0;
      bit_cnt     <= '0;
      coll_cnt    <= '0;
      att_col     <= 1'b0;
      aborted     <= 1'b0;
      crs_seen    <= 1'b0;
      frame_abort <= 1'b0;
    end else begin
      tx_d        <= tx_en;
      frame_abort <= hit_max;

      if (!tx_en)                bit_cnt <= '0;
      else if (bit_cnt < LATE_V) bit_cnt <= bit_cnt + 1'b1;

      if (!tx_en)         att_col <= 1'b0;
      else if (first_col) att_col <= 1'b1;

      if (!tx_en)       aborted <= 1'b0;
      else if (hit_max) aborted <= 1'b1;

      if (!tx_en)   crs_seen <= 1'b0;
      else if (crs) crs_seen <= 1'b1;

      if (ev.done)        coll_cnt <= '0;
      else if (first_col) coll_cnt <= coll_cnt + 1'b1;
    end
  end

  // R4
  coll_cap_chk: assert property (@(posedge clk) disable iff (rst)
    coll_cnt < CCW'(MAX_COLL));

  // R4
  abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_abort |=> !frame_abort);
endmodule

// File: rtl/eth_txmon_defer.sv
module eth_txmon_defer #(
  parameter int LIMIT = 24284
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic arm,
  output logic defer_ev
);
  localparam int DW = $clog2(LIMIT);
  localparam logic [DW-1:0] LAST_D = DW'(LIMIT - 1);

  logic          pend;
  logic [DW-1:0] dcnt;

  assign defer_ev = pend && !tx_en && (dcnt == LAST_D);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      dcnt <= '0;
    end else if (tx_en) begin
      pend <= 1'b0;
      dcnt <= '0;
    end else if (arm) begin
      pend <= 1'b1;
      dcnt <= DW'(1);
    end else if (defer_ev) begin
      pend <= 1'b0;
      dcnt <= '0;
    end else if (pend) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  // R6
  dcnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    dcnt <= LAST_D);

  // R6
  defer_once_chk: assert property (@(posedge clk) disable iff (rst)
    defer_ev |=> !defer_ev);
endmodule

// File: rtl/eth_txmon_stsreg.sv
module eth_txmon_stsreg
  import eth_txmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              cpu_wr,
  input  logic [STAT_W-1:0] cpu_wdata,
  input  logic [STAT_W-1:0] irq_en,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] clr, nxt;

  always_comb begin
    clr = cpu_wr ? cpu_wdata : '0;
    nxt = ((status & ~clr) | set_vec) & VALID_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |(nxt & irq_en);
    end
  end

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec & VALID_MASK)) == $past(set_vec & VALID_MASK)));

  // R2
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> ((status & $past(cpu_wdata & ~set_vec)) == '0));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & $past(irq_en)));
endmodule

// File: rtl/eth_tx_status_mon.sv
module eth_tx_status_mon
  import eth_txmon_pkg::*;
#(
  parameter int LATE_BITS   = 512,
  parameter int MAX_COLL    = 16,
  parameter int DEFER_LIMIT = 24284
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_en,
  input  logic        col,
  input  logic        crs,
  input  logic        fifo_empty,
  input  logic        fifo_par_err,
  input  logic        ctrl_sent,
  input  logic        dma_not_owner,
  input  logic        dma_buf_empty,
  input  logic        cpu_wr,
  input  logic [31:0] cpu_wdata,
  input  logic [31:0] irq_en,
  output logic [31:0] cpu_rdata,
  output logic        frame_abort,
  output logic        irq
);
  frame_ev_t         ev;
  logic              defer_ev;
  logic [STAT_W-1:0] set_vec;

  eth_txmon_frame #(
    .LATE_BITS (LATE_BITS),
    .MAX_COLL  (MAX_COLL)
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .col         (col),
    .crs         (crs),
    .fifo_empty  (fifo_empty),
    .ev          (ev),
    .frame_abort (frame_abort)
  );

  eth_txmon_defer #(
    .LIMIT (DEFER_LIMIT)
  ) u_defer (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .arm      (ev.retry),
    .defer_ev (defer_ev)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_EXCOL] = ev.excol;
    set_vec[B_UNDR]  = ev.undr;
    set_vec[B_DEFER] = defer_ev;
    set_vec[B_NOCRS] = ev.nocrs;
    set_vec[B_LATE]  = ev.late;
    set_vec[B_PAR]   = fifo_par_err;
    set_vec[B_DONE]  = ev.done;
    set_vec[B_CTRL]  = ctrl_sent;
    set_vec[B_NOOWN] = dma_not_owner;
    set_vec[B_BUFE]  = dma_buf_empty;
  end

  eth_txmon_stsreg u_sts (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .irq_en    (irq_en),
    .status    (cpu_rdata),
    .irq       (irq)
  );

  // R4
  abort_flags_chk: assert property (@(posedge clk) disable iff (rst)
    frame_abort |-> (cpu_rdata[B_EXCOL] && cpu_rdata[B_DONE]));
endmodule

// File: tb/tb_eth_tx_status_mon.sv
`timescale 1ns/1ps
module tb_eth_tx_status_mon;
  localparam int LATE = 512;
  localparam int MAXC = 16;
  localparam int LIM  = 24284;
  localparam logic [31:0] VMASK = 32'h0007_007F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 0, col = 0, crs = 0, fifo_empty = 0, fifo_par_err = 0;
  logic ctrl_sent = 0, dma_not_owner = 0, dma_buf_empty = 0, cpu_wr = 0;
  logic [31:0] cpu_wdata = '0, irq_en = '0;
  logic [31:0] cpu_rdata;
  logic frame_abort, irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eth_tx_status_mon #(.LATE_BITS(LATE), .MAX_COLL(MAXC), .DEFER_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .col(col), .crs(crs),
    .fifo_empty(fifo_empty), .fifo_par_err(fifo_par_err), .ctrl_sent(ctrl_sent),
    .dma_not_owner(dma_not_owner), .dma_buf_empty(dma_buf_empty),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .irq_en(irq_en),
    .cpu_rdata(cpu_rdata), .frame_abort(frame_abort), .irq(irq));

  // reference state, written from the requirements
  logic [31:0] m_stat;
  logic m_abort, m_irq, m_prev_tx, m_collided, m_dead, m_crs_seen, m_owed;
  int m_streak, m_idx, m_low;

  function automatic string req_of(int b);
    case (b)
      0: return "R4";  1: return "R5";  2: return "R6";  3: return "R7";
      4: return "R8";  6: return "R10";
      5, 16, 17, 18: return "R9";
      default: return "R3";
    endcase
  endfunction

  function automatic int low_diff(logic [31:0] a, logic [31:0] b);
    for (int i = 0; i < 32; i++) if (a[i] != b[i]) return i;
    return 0;
  endfunction

  task automatic model_step();
    logic [31:0] ev;
    logic live, ending;
    ev = '0;
    if (rst) begin
      m_stat = '0; m_abort = 0; m_irq = 0; m_prev_tx = 0; m_collided = 0;
      m_dead = 0; m_crs_seen = 0; m_owed = 0; m_streak = 0; m_idx = 0; m_low = 0;
      return;
    end
    live   = tx_en && !m_dead;
    ending = m_prev_tx && !tx_en;
    m_abort = 0;
    if (live && fifo_empty) ev[1] = 1;
    if (live && col) begin
      if (m_idx >= LATE) ev[4] = 1;
      if (!m_collided) begin
        m_collided = 1;
        m_streak++;
        if (m_streak == MAXC) begin
          ev[0] = 1; ev[6] = 1; m_abort = 1; m_dead = 1; m_streak = 0;
        end
      end
    end
    if (tx_en && crs) m_crs_seen = 1;
    if (ending) begin
      if (!m_crs_seen) ev[3] = 1;
      if (!m_dead) begin
        if (m_collided) begin m_owed = 1; m_low = 0; end
        else begin ev[6] = 1; m_streak = 0; end
      end
    end
    if (tx_en) begin
      m_owed = 0; m_low = 0; m_idx++;
    end else begin
      if (m_owed) begin
        m_low++;
        if (m_low == LIM) begin ev[2] = 1; m_owed = 0; end
      end
      m_idx = 0; m_collided = 0; m_dead = 0; m_crs_seen = 0;
    end
    m_prev_tx = tx_en;
    ev[5]  = fifo_par_err;
    ev[16] = ctrl_sent;
    ev[17] = dma_not_owner;
    ev[18] = dma_buf_empty;
    m_stat = ((m_stat & ~(cpu_wr ? cpu_wdata : 32'h0)) | ev) & VMASK;
    m_irq  = |(m_stat & irq_en);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    nchk++;
    if (cpu_rdata !== m_stat) begin
      nerr++;
      $display("FAIL %s status actual=%h expected=%h", req_of(low_diff(cpu_rdata, m_stat)),
               cpu_rdata, m_stat);
    end
    nchk++;
    if (frame_abort !== m_abort) begin
      nerr++;
      $display("FAIL R4 frame_abort actual=%0b expected=%0b", frame_abort, m_abort);
    end
    nchk++;
    if (irq !== m_irq) begin
      nerr++;
      $display("FAIL R11 irq actual=%0b expected=%0b", irq, m_irq);
    end
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    tx_en = 0; col = 0; crs = 0; fifo_empty = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  // crs_mode: -2 carrier in every cycle, -1 never, k only in cycle k
  task automatic attempt(int len, int col_at, int crs_mode, int empty_at);
    for (int i = 0; i < len; i++) begin
      tx_en = 1;
      col = (i == col_at);
      crs = (crs_mode == -2) || (crs_mode == i);
      fifo_empty = (i == empty_at);
      tick();
    end
    idle(1);
  endtask

  task automatic clear_all();
    cpu_wr = 1; cpu_wdata = '1; tick(); cpu_wr = 0; cpu_wdata = '0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();
    check(cpu_rdata == 0 && !irq && !frame_abort, "R1 reset", cpu_rdata, 0);

    // R2 write-one-to-clear
    fifo_par_err = 1; tick(); fifo_par_err = 0;
    cpu_wr = 1; cpu_wdata = 0; tick();
    check(cpu_rdata[5], "R2 zero write keeps", cpu_rdata, 32'h20);
    cpu_wdata = 32'h20; tick();
    check(!cpu_rdata[5], "R2 one clears", cpu_rdata, 0);
    fifo_par_err = 1; tick(); fifo_par_err = 0; cpu_wr = 0; cpu_wdata = 0;
    check(cpu_rdata[5], "R2 set wins", cpu_rdata, 32'h20);

    // R9 pulses
    clear_all();
    ctrl_sent = 1; dma_not_owner = 1; dma_buf_empty = 1; tick();
    ctrl_sent = 0; dma_not_owner = 0; dma_buf_empty = 0;
    check(cpu_rdata == 32'h0007_0000, "R9 dma/ctrl bits", cpu_rdata, 32'h0007_0000);

    // R11 interrupt mask
    clear_all();
    fifo_par_err = 1; tick(); fifo_par_err = 0;
    check(!irq, "R11 masked", {31'b0, irq}, 0);
    irq_en = 32'h20; tick();
    check(irq, "R11 enabled", {31'b0, irq}, 1);
    irq_en = ~32'h20; tick();
    check(!irq, "R11 other bits enabled", {31'b0, irq}, 0);
    irq_en = 0;

    // R10 clean completion, R7 carrier
    clear_all();
    attempt(40, -1, 7, -1);
    check(cpu_rdata == 32'h40, "R10 done, R7 carrier once", cpu_rdata, 32'h40);
    clear_all();
    attempt(40, -1, -1, -1);
    check(cpu_rdata == 32'h48, "R7 no carrier", cpu_rdata, 32'h48);

    // R5 underflow
    clear_all();
    fifo_empty = 1; tick(); fifo_empty = 0;
    check(!cpu_rdata[1], "R5 empty while idle", cpu_rdata, 0);
    attempt(30, -1, -2, 5);
    check(cpu_rdata[1], "R5 underflow", cpu_rdata, 32'h42);

    // R8 late collision boundary
    clear_all();
    attempt(520, 511, -2, -1);
    check(!cpu_rdata[4], "R8 at 511", cpu_rdata, 0);
    attempt(520, 512, -2, -1);
    check(cpu_rdata[4], "R8 at 512", cpu_rdata, 32'h10);
    attempt(30, -1, -2, -1);

    // R4 excessive collisions
    clear_all();
    for (int a = 0; a < MAXC - 1; a++) begin attempt(40, 10, -2, -1); idle(4); end
    check(!cpu_rdata[0], "R4 fifteen collided", cpu_rdata, 0);
    tx_en = 1; crs = 1;
    for (int i = 0; i < 10; i++) tick();
    col = 1; tick(); col = 0;
    check(frame_abort && cpu_rdata[0] && cpu_rdata[6], "R4 R10 abort on 16th",
          cpu_rdata, 32'h41);
    tick();
    check(!frame_abort, "R4 abort one cycle", {31'b0, frame_abort}, 0);
    idle(3);
    clear_all();
    for (int a = 0; a < MAXC - 1; a++) begin attempt(40, 10, -2, -1); idle(4); end
    check(!cpu_rdata[0], "R4 count restarted after abort", cpu_rdata, 0);
    attempt(40, -1, -2, -1);

    // R6 deferral window
    clear_all();
    attempt(40, 10, -2, -1);
    idle(LIM - 2);
    check(!cpu_rdata[2], "R6 one short of limit", cpu_rdata, 0);
    idle(1);
    check(cpu_rdata[2], "R6 limit reached", cpu_rdata, 32'h4);
    attempt(40, -1, -2, -1);
    clear_all();
    attempt(40, 10, -2, -1);
    idle(LIM - 2);
    attempt(40, -1, -2, -1);
    idle(LIM + 5);
    check(!cpu_rdata[2], "R6 resumed in time", cpu_rdata, 0);

    // random traffic against the reference
    begin
      int rem = 0, idx = 0, colpos = -1;
      bit in_tx = 0, crs_on = 1, storm = 0;
      for (int c = 0; c < 40000; c++) begin
        if (rem == 0) begin
          if (in_tx) begin
            in_tx = 0; rem = $urandom_range(5, 60);
          end else begin
            in_tx = 1; idx = 0; rem = $urandom_range(20, 700);
            if (m_streak == 0) storm = ($urandom_range(0, 1) == 1);
            colpos = ($urandom_range(0, 99) < (storm ? 95 : 10)) ? $urandom_range(0, rem - 1) : -1;
            crs_on = ($urandom_range(0, 99) < 85);
          end
        end
        tx_en = in_tx;
        col = in_tx && (idx == colpos);
        crs = in_tx && crs_on;
        fifo_empty   = ($urandom_range(0, 399) == 0);
        fifo_par_err = ($urandom_range(0, 499) == 0);
        ctrl_sent     = ($urandom_range(0, 299) == 0);
        dma_not_owner = ($urandom_range(0, 299) == 0);
        dma_buf_empty = ($urandom_range(0, 299) == 0);
        cpu_wr = ($urandom_range(0, 49) == 0);
        cpu_wdata = $urandom;
        if ((c % 64) == 0) irq_en = $urandom;
        tick();
        rem--; idx++;
      end
    end
    idle(2);
    cpu_wr = 0; fifo_empty = 0; fifo_par_err = 0;
    ctrl_sent = 0; dma_not_owner = 0; dma_buf_empty = 0;
    check((cpu_rdata & ~VMASK) == 0, "R3 reserved zero", cpu_rdata & ~VMASK, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule